// File: doc/BRIEF.md
# Accelerator command and status unit

This unit accepts one command at a time for an accelerator that owns several work queues. Software writes a 32-bit command word that holds an opcode, an operand and a request for a completion interrupt. The unit raises an active flag in its status word at once and validates the command against the present device state and the enable bit of the queue it names. After a fixed number of cycles it commits the resulting state change, writes an error code and a 16-bit result into the status word, and drops the active flag.

The device moves through four states: off, running, draining and halted. Queue commands index a per-queue enable vector with the low operand bits. When the command asked for it, completion sets a cause bit that software clears by writing a one to it. Every rejected transition leaves the state untouched and reports its own error code.

Top module: `dev_cmd_ctrl`

## Requirements
- R1: Command word layout: bit 31 is the interrupt request, bits 24:20 the opcode, bits 19:0 the operand. A write while idle sets status bit 31 (active) in the next cycle and clears status bits 23:0.
- R2: Status bit 31 stays 1 for exactly CMD_LAT cycles (default 4). At the edge that clears it, status bits 7:0 take the error code, bits 23:8 the result, bits 30:24 read 0, and the state and queue enables change only there.
- R3: A command written while status bit 31 is 1 is dropped: it changes no status bit, state or queue enable.
- R4: Opcode 0 and opcodes 14 to 31 complete with error 1 and change nothing.
- R5: Opcode 1 (enable device) moves state 0 (off) to 1 (running) with error 0. From any other state it reports 0x10 with no change.
- R6: Opcode 2 (disable device) in state 1 moves to state 0 and clears every queue enable. In any other state it reports 0x31.
- R7: Opcode 3 (drain all) in state 1 shows state 2 while active and returns to state 1. Opcode 4 (abort all) in state 1 moves to state 3 (halted) and clears every queue enable. Outside state 1 both report 0x32.
- R8: Opcode 5 (reset device) always succeeds, sets state 0 and clears all queue enables.
- R9: For opcodes 6 to 10 an operand of NQ (default 8) or more reports error 2, and this check comes first.
- R10: Opcode 6 (enable queue) reports 0x20 unless the state is 1, and 0x21 if the queue is already enabled. Otherwise it sets the enable bit of queue operand[2:0].
- R11: Opcodes 7 (disable queue), 8 (drain queue), 9 (abort queue) and 10 (reset queue) report 0x32 unless the state is 1. Otherwise 7, 9 and 10 clear the queue's enable bit and 8 leaves it set.
- R12: Opcodes 11 and 12 (drain or abort by address space) succeed only in state 1, otherwise 0x32, and change nothing. Opcode 13 (request interrupt handle) always succeeds with result = operand[15:0].
- R13: Cause bit 1 is set at completion only if the command's bit 31 was 1. A cause write with data bit 1 set clears it. If the set and the clear fall on the same edge, the set wins.
- R14: After reset the status word, the state, the queue enables and the cause word all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr_en | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word |
| cause_wr_en | input | 1 | Cause register write strobe (write one to clear) |
| cause_wdata | input | 32 | Cause write data; bit 1 clears completion |
| status_o | output | 32 | Status word: error, result, active |
| dev_state_o | output | 2 | Device state: 0 off, 1 running, 2 draining, 3 halted |
| q_en_o | output | NQ | Per-queue enable bits |
| cause_o | output | 32 | Interrupt cause word; bit 1 is command completion |

## Verification
Two pairs of functions can meet on one edge. The first is a command completing and setting the cause bit while software writes one to clear that bit. The bench raises the cause write in the last active cycle of a command that asked for an interrupt, and expects the bit to read 1 afterwards. With a non-interrupting command in the same position it expects the bit to read 0. The second pair is a new command word arriving while the previous one is still active. The bench injects a conflicting command (reset device) mid-flight and judges the final status, state and queue enables against the first command alone.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    typedef enum logic [1:0] {
        DEV_OFF   = 2'd0,
        DEV_ON    = 2'd1,
        DEV_DRAIN = 2'd2,
        DEV_HALT  = 2'd3
    } dev_state_e;

    typedef enum logic [4:0] {
        OP_DEV_EN      = 5'd1,
        OP_DEV_DIS     = 5'd2,
        OP_DRAIN_ALL   = 5'd3,
        OP_ABORT_ALL   = 5'd4,
        OP_DEV_RST     = 5'd5,
        OP_Q_EN        = 5'd6,
        OP_Q_DIS       = 5'd7,
        OP_Q_DRAIN     = 5'd8,
        OP_Q_ABORT     = 5'd9,
        OP_Q_RST       = 5'd10,
        OP_SPACE_DRAIN = 5'd11,
        OP_SPACE_ABORT = 5'd12,
        OP_INT_HANDLE  = 5'd13
    } opcode_e;

    typedef enum logic [1:0] {
        QOP_KEEP  = 2'd0,
        QOP_SET   = 2'd1,
        QOP_CLR   = 2'd2,
        QOP_WIPE  = 2'd3
    } qop_e;

    localparam logic [7:0] E_OK          = 8'h00;
    localparam logic [7:0] E_BAD_OP      = 8'h01;
    localparam logic [7:0] E_BAD_QIDX    = 8'h02;
    localparam logic [7:0] E_DEV_ALREADY = 8'h10;
    localparam logic [7:0] E_QEN_DEV_OFF = 8'h20;
    localparam logic [7:0] E_Q_ALREADY   = 8'h21;
    localparam logic [7:0] E_DIS_NOT_ON  = 8'h31;
    localparam logic [7:0] E_Q_DEV_OFF   = 8'h32;

    localparam int CAUSE_DONE_BIT = 1;
    localparam int ARG_W          = 20;

    typedef struct packed {
        logic             irq;
        logic [5:0]       rsvd;
        logic [4:0]       op;
        logic [ARG_W-1:0] arg;
    } cmd_word_t;

    typedef struct packed {
        logic [7:0]  err;
        logic [15:0] res;
        dev_state_e  busy_st;
        dev_state_e  fin_st;
        qop_e        qop;
    } outcome_t;

    function automatic outcome_t judge(input cmd_word_t cw, input dev_state_e st,
                                       input logic idx_ok, input logic q_on);
        outcome_t o;
        logic     on;
        on        = (st == DEV_ON);
        o.err     = E_OK;
        o.res     = '0;
        o.busy_st = st;
        o.fin_st  = st;
        o.qop     = QOP_KEEP;
        case (cw.op)
            OP_DEV_EN: begin
                if (st != DEV_OFF) o.err = E_DEV_ALREADY;
                else               o.fin_st = DEV_ON;
            end
            OP_DEV_DIS: begin
                if (!on) o.err = E_DIS_NOT_ON;
                else begin
                    o.fin_st = DEV_OFF;
                    o.qop    = QOP_WIPE;
                end
            end
            OP_DRAIN_ALL: begin
                if (!on) o.err = E_Q_DEV_OFF;
                else     o.busy_st = DEV_DRAIN;
            end
            OP_ABORT_ALL: begin
                if (!on) o.err = E_Q_DEV_OFF;
                else begin
                    o.fin_st = DEV_HALT;
                    o.qop    = QOP_WIPE;
                end
            end
            OP_DEV_RST: begin
                o.fin_st = DEV_OFF;
                o.qop    = QOP_WIPE;
            end
            OP_Q_EN: begin
                if (!idx_ok)   o.err = E_BAD_QIDX;
                else if (!on)  o.err = E_QEN_DEV_OFF;
                else if (q_on) o.err = E_Q_ALREADY;
                else           o.qop = QOP_SET;
            end
            OP_Q_DIS, OP_Q_ABORT, OP_Q_RST: begin
                if (!idx_ok)  o.err = E_BAD_QIDX;
                else if (!on) o.err = E_Q_DEV_OFF;
                else          o.qop = QOP_CLR;
            end
            OP_Q_DRAIN: begin
                if (!idx_ok)  o.err = E_BAD_QIDX;
                else if (!on) o.err = E_Q_DEV_OFF;
            end
            OP_SPACE_DRAIN, OP_SPACE_ABORT: begin
                if (!on) o.err = E_Q_DEV_OFF;
            end
            OP_INT_HANDLE: begin
                o.res = cw.arg[15:0];
            end
            default: o.err = E_BAD_OP;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/dcc_decode.sv
module dcc_decode
    import dcc_pkg::*;
#(
    parameter int NQ = 8,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic [31:0]   cmd_word,
    input  dev_state_e    cur_st,
    input  logic [NQ-1:0] q_en,
    output outcome_t      verdict,
    output logic [QW-1:0] q_idx
);

    cmd_word_t cw;
    logic      idx_ok;
    logic      q_on;

    always_comb begin
        cw      = cmd_word_t'(cmd_word);
        q_idx   = cw.arg[QW-1:0];
        idx_ok  = (32'(cw.arg) < NQ);
        q_on    = idx_ok ? q_en[q_idx] : 1'b0;
        verdict = judge(cw, cur_st, idx_ok, q_on);
    end

endmodule

// File: rtl/dcc_timer.sv
module dcc_timer #(
    parameter int CMD_LAT = 4,
    localparam int CW = $clog2(CMD_LAT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);

    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            left <= '0;
        end else if (start) begin
            busy <= 1'b1;
            left <= CW'(CMD_LAT - 1);
        end else if (busy) begin
            if (left == '0) busy <= 1'b0;
            else            left <= left - 1'b1;
        end
    end

    assign done = busy && (left == '0);

endmodule

// File: rtl/dcc_cause.sv
module dcc_cause
    import dcc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        set_done,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] cause
);

    logic done_bit;

    always_ff @(posedge clk) begin
        if (rst)                                  done_bit <= 1'b0;
        else if (set_done)                        done_bit <= 1'b1;
        else if (wr_en && wr_data[CAUSE_DONE_BIT]) done_bit <= 1'b0;
    end

    always_comb begin
        cause                 = '0;
        cause[CAUSE_DONE_BIT] = done_bit;
    end

endmodule

// File: rtl/dev_cmd_ctrl.sv
module dev_cmd_ctrl
    import dcc_pkg::*;
#(
    parameter int NQ      = 8,
    parameter int CMD_LAT = 4,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_wr_en,
    input  logic [31:0]   cmd_wdata,
    input  logic          cause_wr_en,
    input  logic [31:0]   cause_wdata,
    output logic [31:0]   status_o,
    output logic [1:0]    dev_state_o,
    output logic [NQ-1:0] q_en_o,
    output logic [31:0]   cause_o
);

    dev_state_e    st_q;
    logic [NQ-1:0] q_en_q;
    outcome_t      verdict;
    outcome_t      held_q;
    logic [QW-1:0] idx_now;
    logic [QW-1:0] idx_q;
    logic          irq_q;
    logic [7:0]    err_q;
    logic [15:0]   res_q;
    logic          busy;
    logic          done;
    logic          accept;

    assign accept = cmd_wr_en && !busy;

    dcc_decode #(.NQ(NQ)) u_decode (
        .cmd_word (cmd_wdata),
        .cur_st   (st_q),
        .q_en     (q_en_q),
        .verdict  (verdict),
        .q_idx    (idx_now)
    );

    dcc_timer #(.CMD_LAT(CMD_LAT)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .busy  (busy),
        .done  (done)
    );

    dcc_cause u_cause (
        .clk      (clk),
        .rst      (rst),
        .set_done (done && irq_q),
        .wr_en    (cause_wr_en),
        .wr_data  (cause_wdata),
        .cause    (cause_o)
    );

    // Verdict is taken when the word is accepted and committed on completion.
    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
            idx_q  <= '0;
            irq_q  <= 1'b0;
        end else if (accept) begin
            held_q <= verdict;
            idx_q  <= idx_now;
            irq_q  <= cmd_wdata[31];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         st_q <= DEV_OFF;
        else if (accept) st_q <= verdict.busy_st;
        else if (done)   st_q <= held_q.fin_st;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
            res_q <= '0;
        end else if (accept) begin
            err_q <= '0;
            res_q <= '0;
        end else if (done) begin
            err_q <= held_q.err;
            res_q <= held_q.res;
        end
    end

    for (genvar g = 0; g < NQ; g++) begin : g_queue
        logic hit;
        assign hit = (idx_q == QW'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                q_en_q[g] <= 1'b0;
            end else if (done) begin
                case (held_q.qop)
                    QOP_SET:  if (hit) q_en_q[g] <= 1'b1;
                    QOP_CLR:  if (hit) q_en_q[g] <= 1'b0;
                    QOP_WIPE: q_en_q[g] <= 1'b0;
                    default:  q_en_q[g] <= q_en_q[g];
                endcase
            end
        end
    end

    assign status_o    = {busy, 7'b0, res_q, err_q};
    assign dev_state_o = st_q;
    assign q_en_o      = q_en_q;

endmodule

// File: rtl/dcc_chk.sv
module dcc_chk #(
    parameter int NQ = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_wr_en,
    input logic [31:0]   status_o,
    input logic [1:0]    dev_state_o,
    input logic [NQ-1:0] q_en_o,
    input logic [31:0]   cause_o
);

    // R1
    accept_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status_o[31]) |-> $past(cmd_wr_en));

    // R3
    busy_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (status_o[31] && $past(status_o[31])) |-> $stable(status_o[30:0]));

    // R2
    q_commit_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(q_en_o) |-> $fell(status_o[31]));

    // R6
    idle_no_queue_chk: assert property (@(posedge clk) disable iff (rst)
        (dev_state_o == 2'd0 || dev_state_o == 2'd3) |-> (q_en_o == '0));

    // R10
    q_set_running_chk: assert property (@(posedge clk) disable iff (rst)
        (|(q_en_o & ~$past(q_en_o))) |-> (dev_state_o == 2'd1));

    // R13
    cause_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cause_o[1]) |-> $fell(status_o[31]));

endmodule

bind dev_cmd_ctrl dcc_chk #(.NQ(NQ)) u_dcc_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_wr_en   (cmd_wr_en),
    .status_o    (status_o),
    .dev_state_o (dev_state_o),
    .q_en_o      (q_en_o),
    .cause_o     (cause_o)
);

// File: tb/sim_dev_cmd_ctrl.sv
module sim_dev_cmd_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NQ  = 8;
    localparam int LAT = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_wr_en = 1'b0;
    logic [31:0]   cmd_wdata = '0;
    logic          cause_wr_en = 1'b0;
    logic [31:0]   cause_wdata = '0;
    logic [31:0]   status_o;
    logic [1:0]    dev_state_o;
    logic [NQ-1:0] q_en_o;
    logic [31:0]   cause_o;

    int checks = 0;
    int fails  = 0;

    logic [1:0]    m_st;
    logic [NQ-1:0] m_q;
    logic          m_cause;

    always #(CLK_PERIOD/2) clk = ~clk;

    dev_cmd_ctrl #(.NQ(NQ), .CMD_LAT(LAT)) u0 (
        .clk(clk), .rst(rst), .cmd_wr_en(cmd_wr_en), .cmd_wdata(cmd_wdata),
        .cause_wr_en(cause_wr_en), .cause_wdata(cause_wdata),
        .status_o(status_o), .dev_state_o(dev_state_o), .q_en_o(q_en_o),
        .cause_o(cause_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int op, input int arg, input bit irq);
        return {irq, 6'b0, 5'(op), 20'(arg)};
    endfunction

    task automatic model(input logic [31:0] w, output logic [7:0] err, output logic [15:0] res,
                         output logic [1:0] bst, output logic [1:0] fst, output logic [NQ-1:0] qn,
                         output string req);
        int  op;
        int  arg;
        bit  on;
        bit  ok;
        op  = int'(w[24:20]);
        arg = int'(w[19:0]);
        on  = (m_st == 2'd1);
        ok  = (arg < NQ);
        err = 8'h00; res = '0; bst = m_st; fst = m_st; qn = m_q;
        case (op)
            1: begin req = "R5"; if (m_st != 0) err = 8'h10; else fst = 2'd1; end
            2: begin req = "R6"; if (!on) err = 8'h31; else begin fst = 0; qn = '0; end end
            3: begin req = "R7"; if (!on) err = 8'h32; else bst = 2'd2; end
            4: begin req = "R7"; if (!on) err = 8'h32; else begin fst = 2'd3; qn = '0; end end
            5: begin req = "R8"; fst = 0; qn = '0; end
            6: begin
                req = "R10";
                if (!ok) begin err = 8'h02; req = "R9"; end
                else if (!on) err = 8'h20;
                else if (m_q[arg]) err = 8'h21;
                else qn[arg] = 1'b1;
            end
            7, 8, 9, 10: begin
                req = "R11";
                if (!ok) begin err = 8'h02; req = "R9"; end
                else if (!on) err = 8'h32;
                else if (op != 8) qn[arg] = 1'b0;
            end
            11, 12: begin req = "R12"; if (!on) err = 8'h32; end
            13: begin req = "R12"; res = w[15:0]; end
            default: begin req = "R4"; err = 8'h01; end
        endcase
    endtask

    task automatic run(input logic [31:0] w, input bit clr_end, input bit inject, input logic [31:0] inj);
        logic [7:0]    e_err;
        logic [15:0]   e_res;
        logic [1:0]    e_bst;
        logic [1:0]    e_fst;
        logic [NQ-1:0] e_q;
        string         req;
        model(w, e_err, e_res, e_bst, e_fst, e_q, req);
        @(negedge clk);
        cmd_wr_en = 1'b1;
        cmd_wdata = w;
        @(negedge clk);
        cmd_wr_en = 1'b0;
        // R1: active bit rises, low fields cleared
        chk(status_o[31] == 1'b1 && status_o[23:0] == '0, "R1", status_o, {1'b1, 31'b0});
        chk(dev_state_o == e_bst, (e_bst == 2'd2) ? "R7" : "R2", 32'(dev_state_o), 32'(e_bst));
        for (int i = 1; i < LAT; i++) begin
            if (inject && i == 1) begin
                cmd_wr_en = 1'b1;
                cmd_wdata = inj;
            end
            @(negedge clk);
            cmd_wr_en = 1'b0;
            if (i == LAT - 1) begin
                // R2: still active one cycle before the end
                chk(status_o[31] == 1'b1, "R2", status_o, 32'h8000_0000);
                if (clr_end) begin
                    cause_wr_en = 1'b1;
                    cause_wdata = 32'h2;
                end
            end
        end
        @(negedge clk);
        cause_wr_en = 1'b0;
        cause_wdata = '0;
        m_st = e_fst;
        m_q  = e_q;
        if (w[31])       m_cause = 1'b1;
        else if (clr_end) m_cause = 1'b0;
        chk(status_o == {1'b0, 7'b0, e_res, e_err}, inject ? "R3" : req, status_o, {8'b0, e_res, e_err});
        chk(dev_state_o == e_fst, req, 32'(dev_state_o), 32'(e_fst));
        chk(q_en_o == e_q, req, 32'(q_en_o), 32'(e_q));
        chk(cause_o == {30'b0, m_cause, 1'b0}, "R13", cause_o, {30'b0, m_cause, 1'b0});
    endtask

    task automatic cause_write(input logic [31:0] d);
        @(negedge clk);
        cause_wr_en = 1'b1;
        cause_wdata = d;
        @(negedge clk);
        cause_wr_en = 1'b0;
        cause_wdata = '0;
        if (d[1]) m_cause = 1'b0;
        chk(cause_o == {30'b0, m_cause, 1'b0}, "R13", cause_o, {30'b0, m_cause, 1'b0});
    endtask

    task automatic finish_up();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        m_st = 0; m_q = '0; m_cause = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R14 reset values
        chk(status_o == '0, "R14", status_o, 0);
        chk(dev_state_o == 0 && q_en_o == '0, "R14", {dev_state_o, 22'b0, q_en_o}, 0);
        chk(cause_o == '0, "R14", cause_o, 0);

        run(mk(1, 0, 0), 0, 0, 0);            // R5 off -> running
        run(mk(1, 0, 0), 0, 0, 0);            // R5 already running
        run(mk(6, 3, 1), 0, 0, 0);            // R10 enable queue, irq
        cause_write(32'h1);                   // R13 bit 0 has no effect
        cause_write(32'h2);                   // R13 clear
        run(mk(6, 3, 0), 0, 0, 0);            // R10 already enabled
        run(mk(6, NQ, 0), 0, 0, 0);           // R9 just out of range
        run(mk(9, 20'hFFFFF, 0), 0, 0, 0);    // R9 largest operand
        run(mk(0, 0, 0), 0, 0, 0);            // R4
        run(mk(31, 5, 0), 0, 0, 0);           // R4
        run(mk(13, 20'hABCDE, 0), 0, 0, 0);   // R12 handle result
        run(mk(3, 0, 0), 0, 0, 0);            // R7 drain shows state 2
        run(mk(8, 3, 0), 0, 0, 0);            // R11 drain keeps queue
        run(mk(7, 3, 0), 0, 0, 0);            // R11 disable clears queue
        run(mk(6, 5, 0), 0, 0, 0);
        run(mk(2, 0, 0), 0, 0, 0);            // R6 disable wipes queues
        run(mk(2, 0, 0), 0, 0, 0);            // R6 not running
        run(mk(7, 1, 0), 0, 0, 0);            // R11 device off
        run(mk(6, 1, 0), 0, 0, 0);            // R10 device off
        run(mk(11, 0, 0), 0, 0, 0);           // R12 device off
        run(mk(1, 0, 0), 0, 0, 0);
        run(mk(6, 2, 0), 0, 0, 0);
        run(mk(4, 0, 0), 0, 0, 0);            // R7 abort -> halted
        run(mk(1, 0, 0), 0, 0, 0);            // R5 from halted
        run(mk(3, 0, 0), 0, 0, 0);            // R7 while halted
        run(mk(5, 0, 0), 0, 0, 0);            // R8 reset device
        run(mk(1, 0, 0), 0, 1, mk(5, 0, 1));  // R3 write while active dropped
        run(mk(13, 7, 1), 1, 0, 0);           // R13 set wins over clear
        run(mk(0, 0, 0), 1, 0, 0);            // R13 clear with no set

        for (int n = 0; n < 300; n++) begin
            int op;
            int arg;
            op  = ($urandom % 8 == 0) ? int'($urandom % 32) : int'($urandom % 14);
            if (op == 2 && ($urandom % 2 == 0)) op = 6;
            arg = ($urandom % 6 == 0) ? int'($urandom % 20'hFFFFF) : int'($urandom % NQ);
            run(mk(op, arg, 1'($urandom % 2)), 1'($urandom % 5 == 0),
                1'($urandom % 6 == 0), mk(int'($urandom % 14), int'($urandom % NQ), 1'b1));
        end
        finish_up();
    end

endmodule